// File: doc/BRIEF.md
# Pulse-Interval Window Receive Detector

This block measures the time between qualifying transitions on a serial input that has already passed through a noise filter. It raises a one-cycle receive interrupt only when the measured interval lies inside a programmed window. A typical use is decoding infrared remote-control pulse trains. A 16-bit free-running counter runs on the count clock. One edge detector restarts the counter from zero. A second edge detector samples a window flag and decides whether the interrupt fires.

The window flag is set when the counter reaches the lower bound. It is cleared when the counter restarts, when the counter reaches the upper bound, or when the counter saturates. When both detectors watch the same polarity, one transition both closes the current interval and opens the next one. A transition that coincides with the lower-bound match still counts as inside the window, even though the same transition restarts the counter. The counter value and the window flag are visible as outputs.

Top module: `pid_window_rx`

## Requirements
- R1: An asynchronous active-low reset forces `count` to 0, `win_flag` to 0 and `irq` to 0 without waiting for a clock edge.
- R2: On each clock the counter advances by one. At FFFFh it holds its value until a restart.
- R3: `edge_cfg[1:0]` selects the restart edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge makes `count` read 0 on the following cycle. Edges that are not selected leave the count running.
- R4: When the counter value equals `min_bound` (below FFFFh, with no restart, and not also equal to `max_bound`), `win_flag` reads 1 on the next cycle.
- R5: `win_flag` is cleared on the cycle after any of these: a restart, a match with `max_bound`, or a count of FFFFh. A clear takes precedence over a set in the same cycle.
- R6: `edge_cfg[3:2]` selects the interrupt edge, with the same encoding as R3. A selected edge raises `irq` for exactly one cycle, on the next cycle, if the counter value at the edge lies in [`min_bound`, `max_bound`] inclusive.
- R7: An interrupt edge that lands in the same cycle as the lower-bound match still produces `irq`, even when that edge also restarts the counter.
- R8: An interrupt edge that arrives with the count below `min_bound`, or after the upper-bound match, produces no `irq`.
- R9: While the count is at FFFFh, no edge produces `irq`.
- R10: The two detectors act independently. With restart set to none, interrupt edges fire without clearing the count. With interrupt set to none, restarts occur with no `irq`.
- R11: The first input sample after reset is never treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Noise-filtered serial input |
| edge_cfg | input | 4 | [1:0] restart edge select, [3:2] interrupt edge select |
| min_bound | input | 16 | Lower window bound |
| max_bound | input | 16 | Upper window bound |
| count | output | 16 | Current counter value |
| win_flag | output | 1 | Window flag |
| irq | output | 1 | One-cycle receive interrupt |

## Verification
The case hardest to reach is the three-way coincidence: the restart, the lower-bound match and the interrupt sample all fall in one cycle. The bench waits at the falling clock edge until the `count` output equals `min_bound`, then drives the falling transition at that moment, so that the next rising edge sees all three at once. Saturation is reached by letting the counter run freely to FFFFh. The bench then holds it there for several cycles before applying an edge.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int NUM_DET     = 2;
  localparam int DET_RESTART = 0;
  localparam int DET_IRQ     = 1;
endpackage

// File: rtl/pid_in_sampler.sv
module pid_in_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  logic sig_q, sig_d;
  logic armed_q, armed_d;

  always_comb begin
    sig_d   = sig_in;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sig_q   <= sig_d;
      armed_q <= armed_d;
    end
  end

  // no edge until one real sample has been taken
  assign rise = armed_q &  sig_in & ~sig_q;
  assign fall = armed_q & ~sig_in &  sig_q;
endmodule

// File: rtl/pid_edge_sel.sv
module pid_edge_sel
  import pid_pkg::*;
(
  input  edge_sel_e sel,
  input  logic      rise,
  input  logic      fall,
  output logic      hit
);
  always_comb begin
    unique case (sel)
      EDGE_NONE: hit = 1'b0;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pid_counter.sv
module pid_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             sat
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign sat    = &cnt_q;
  assign cnt_en = restart | ~sat;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (!sat)   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pid_window.sv
module pid_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             sat,
  input  logic             restart,
  input  logic             irq_edge,
  input  logic [CNT_W-1:0] min_bound,
  input  logic [CNT_W-1:0] max_bound,
  output logic             flag,
  output logic             irq
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;
  logic min_hit, max_hit, qual;

  assign min_hit = (count == min_bound);
  assign max_hit = (count == max_bound);
  // a same-cycle min match counts as set for this sample
  assign qual    = (flag_q | min_hit) & ~sat;

  always_comb begin
    flag_d = flag_q;
    if (restart || max_hit || sat) flag_d = 1'b0;
    else if (min_hit)              flag_d = 1'b1;
    irq_d = irq_edge & qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/pid_window_rx.sv
module pid_window_rx
  import pid_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_in,
  input  logic [2*NUM_DET-1:0] edge_cfg,
  input  logic [CNT_W-1:0]     min_bound,
  input  logic [CNT_W-1:0]     max_bound,
  output logic [CNT_W-1:0]     count,
  output logic                 win_flag,
  output logic                 irq
);
  logic               rise, fall;
  logic [NUM_DET-1:0] det_hit;
  logic               restart_pulse, irq_edge, sat;

  pid_in_sampler u_samp (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (sig_in),
    .rise   (rise),
    .fall   (fall)
  );

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    pid_edge_sel u_sel (
      .sel  (edge_sel_e'(edge_cfg[2*g +: 2])),
      .rise (rise),
      .fall (fall),
      .hit  (det_hit[g])
    );
  end

  assign restart_pulse = det_hit[DET_RESTART];
  assign irq_edge      = det_hit[DET_IRQ];

  pid_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_pulse),
    .count   (count),
    .sat     (sat)
  );

  pid_window #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .sat       (sat),
    .restart   (restart_pulse),
    .irq_edge  (irq_edge),
    .min_bound (min_bound),
    .max_bound (max_bound),
    .flag      (win_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/pid_window_rx_chk.sv
module pid_window_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sig_in,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] min_bound,
  input logic [CNT_W-1:0] max_bound,
  input logic             win_flag,
  input logic             irq,
  input logic             restart,
  input logic             irq_edge
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !restart) |=> (count == TOP)); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0)); // R3

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == min_bound && count != TOP && count != max_bound && !restart) |=> win_flag); // R4

  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !win_flag); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_edge)); // R6

  AST_NO_IRQ_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_edge && count < min_bound && !win_flag) |=> !irq); // R8

  AST_SAT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_edge && count == TOP) |=> !irq); // R9

  AST_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !restart); // R11

  always_comb begin
    if (!rst_n) AST_RESET_IRQ: assert (!irq || $isunknown(sig_in)); // R1
  end
endmodule

bind pid_window_rx pid_window_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sig_in    (sig_in),
  .count     (count),
  .min_bound (min_bound),
  .max_bound (max_bound),
  .win_flag  (win_flag),
  .irq       (irq),
  .restart   (restart_pulse),
  .irq_edge  (irq_edge)
);

// File: tb/tb_pid_window_rx.sv
module tb_pid_window_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sig_in;
  logic [3:0]  edge_cfg;
  logic [15:0] min_bound, max_bound;
  logic [15:0] count;
  logic        win_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pid_window_rx dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .edge_cfg(edge_cfg),
    .min_bound(min_bound), .max_bound(max_bound),
    .count(count), .win_flag(win_flag), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_count(input int t);
    while (int'(count) != t) @(negedge clk);
  endtask

  // drive sig_in to v when count reads t; check the result one cycle later
  task automatic edge_at(input int t, input logic v, input bit exp_irq,
                         input bit exp_rst, input string req);
    wait_count(t);
    sig_in = v;
    @(negedge clk);
    chk(req, "irq", irq, exp_irq);
    chk(req, "count", count, exp_rst ? 0 : (t + 1));
    @(negedge clk);
    chk(req, "irq single cycle", irq, 0);
  endtask

  task automatic t_reset_start();
    rst_n = 1'b0; sig_in = 1'b1; edge_cfg = 4'b0101;
    min_bound = 16'd20; max_bound = 16'd40;
    repeat (3) @(negedge clk);
    chk("R1", "count", count, 0);
    chk("R1", "flag", win_flag, 0);
    chk("R1", "irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "count after first sample", count, 1);
    chk("R11", "irq", irq, 0);
    @(negedge clk);
    chk("R2", "count advances", count, 2);
  endtask

  task automatic t_window_falling();
    edge_cfg = 4'b1010;
    edge_at(30, 1'b0, 1, 1, "R6");
    edge_at(5, 1'b1, 0, 0, "R3");    // rising edge ignored in falling mode
    wait_count(8);
    chk("R8", "flag before short edge", win_flag, 0);
    edge_at(10, 1'b0, 0, 1, "R8");
    edge_at(3, 1'b1, 0, 0, "R3");
    edge_at(20, 1'b0, 1, 1, "R7");   // restart, min match and sample together
    chk("R5", "flag after restart", win_flag, 0);
    edge_at(3, 1'b1, 0, 0, "R3");
    wait_count(21);
    chk("R4", "flag set after min", win_flag, 1);
    edge_at(40, 1'b0, 1, 1, "R6");   // upper bound is inclusive
    edge_at(3, 1'b1, 0, 0, "R3");
    wait_count(41);
    chk("R5", "flag cleared by max", win_flag, 0);
    edge_at(50, 1'b0, 0, 1, "R8");
  endtask

  task automatic t_independent();
    edge_cfg = 4'b1000;              // interrupt falling, restart none
    edge_at(3, 1'b1, 0, 0, "R10");
    edge_at(30, 1'b0, 1, 0, "R10");
    edge_at(33, 1'b1, 0, 0, "R10");
    edge_at(36, 1'b0, 1, 0, "R10");
    edge_cfg = 4'b0010;              // restart falling, interrupt none
    edge_at(39, 1'b1, 0, 0, "R10");
    edge_at(45, 1'b0, 0, 1, "R10");
  endtask

  task automatic t_both_edges();
    edge_cfg = 4'b1111;
    edge_at(25, 1'b1, 1, 1, "R3");
    edge_at(22, 1'b0, 1, 1, "R6");
  endtask

  task automatic t_saturate();
    edge_cfg = 4'b1010;
    min_bound = 16'd100; max_bound = 16'hFFFF;
    edge_at(5, 1'b1, 0, 0, "R3");
    wait_count(200);
    chk("R4", "flag set before saturation", win_flag, 1);
    wait_count(65535);
    repeat (3) @(negedge clk);
    chk("R2", "count holds at top", count, 65535);
    chk("R5", "flag cleared at top", win_flag, 0);
    edge_at(65535, 1'b0, 0, 1, "R9");
  endtask

  task automatic t_async_reset();
    min_bound = 16'd20; max_bound = 16'd40;
    wait_count(30);
    chk("R4", "flag set mid-interval", win_flag, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1", "count async", count, 0);
    chk("R1", "flag async", win_flag, 0);
    chk("R1", "irq async", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "count after release", count, 1);
  endtask

  initial begin
    t_reset_start();
    t_window_falling();
    t_independent();
    t_both_edges();
    t_saturate();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule